// File: doc/BRIEF.md
# Seeded CRC16 Generator and Dual-Seed Checker

This block computes a 16-bit CRC, one byte per clock, over a packet's length byte and payload bytes. Two CRC engines run side by side for every packet. One starts from a programmable seed and the other starts from zero. On the transmit side, the value presented at `crc_out` comes from whichever engine was selected when the packet started. The selection is made per packet, so a sender can protect each packet with either seed.

On the receive side, the same two engines run over the incoming length and payload bytes. The two received CRC bytes are then offered on the same byte bus, low byte first. The packet is accepted if the received word equals either engine's result. The block also reports which seed, or both seeds, produced the match.

Checking and generation can be switched off with a level input. When they are off, `crc_out` reads zero and every completed check passes. Packet framing, length counting and any buffering belong to the surrounding logic.

Top module: `crc16_dual_seed`

## Requirements
- R1: After a synchronous active-low reset, `crc_out` is 0x0000 and `chk_done`, `match_ok`, `hit_seed` and `hit_zero` are all 0.
- R2: The CRC uses the polynomial x^16+x^15+x^2+1 (0x8005), processed LSB first with right shifts (reflected constant 0xA001), with no final inversion. A byte accepted on a clock edge is reflected in `crc_out` from that edge. Example: the ASCII bytes "123456789" give 0x4B37 from seed 0xFFFF and 0xBB3D from seed 0x0000.
- R3: `tx_zero_seed`, sampled on the `pkt_start` cycle, selects the engine shown on `crc_out` for the whole packet: 1 selects the zero-seed engine and 0 selects the programmed-seed engine. The `seed` value is also sampled on that cycle.
- R4: `pkt_start` reinitialises both engines, clears the check result (`chk_done` reads 0 in the next cycle) and opens a packet. A byte whose `din_valid` coincides with `pkt_start` is ignored.
- R5: Data bytes (`din_valid`) are accepted only while a packet is open, meaning after `pkt_start` and up to and including the cycle that carries `pkt_end`. At any other time they leave `crc_out` unchanged.
- R6: After `pkt_end`, the first two `crc_valid` bytes on `din` form the received CRC, low byte first. `chk_done` rises one cycle after the second byte and holds until the next `pkt_start`. Further CRC bytes are ignored, and CRC bytes before `pkt_end` are ignored.
- R7: With checking enabled, `hit_seed` is 1 when the received CRC equals the programmed-seed result and `hit_zero` is 1 when it equals the zero-seed result. Both can be 1 at once, for example when the seed is zero. `match_ok` is 1 when either flag is 1.
- R8: With `crc_en` low, `crc_out` reads 0x0000. Once `chk_done` is high, `match_ok` reads 1 and both hit flags read 0.
- R9: A received packet with any single data bit flipped is rejected: `match_ok` is 0 after `chk_done` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| crc_en | input | 1 | Enables CRC generation and checking |
| seed | input | 16 | Programmed seed, sampled at packet start |
| tx_zero_seed | input | 1 | Selects the zero-seed engine for `crc_out` |
| pkt_start | input | 1 | Opens a packet and reinitialises the engines |
| pkt_end | input | 1 | Marks the last data cycle of the packet |
| din | input | 8 | Byte bus carrying data bytes and received CRC bytes |
| din_valid | input | 1 | `din` holds a length or payload byte |
| crc_valid | input | 1 | `din` holds a received CRC byte |
| crc_out | output | 16 | CRC of the selected engine |
| chk_done | output | 1 | Check result is valid |
| match_ok | output | 1 | Received CRC accepted |
| hit_seed | output | 1 | Received CRC matches the programmed-seed result |
| hit_zero | output | 1 | Received CRC matches the zero-seed result |

## Verification
The assertions assume that `din_valid` and `crc_valid` are never high in the same cycle. They also assume that `pkt_start` is a single-cycle strobe that is not raised together with `pkt_end`. The stimulus tasks drive exactly one of these strobes per cycle, apart from a deliberate case where a data byte coincides with `pkt_start` to show that the byte is dropped. Bytes sent outside an open packet and surplus CRC bytes are also injected on purpose, to show that the outputs do not move.

// File: rtl/crc16_pkg.sv
// Shared constants, the packet phase type and the bytewise CRC step.
// The step function assumes the reflected (LSB-first) form of the polynomial.
package crc16_pkg;
    localparam int BYTE_W = 8;
    localparam int CRC_W  = 16;
    localparam logic [CRC_W-1:0] POLY = 16'h8005;

    typedef enum logic [1:0] {PH_IDLE, PH_DATA, PH_TAIL} phase_t;

    // Bit-reverse a CRC-wide word.
    function automatic logic [CRC_W-1:0] reflect(input logic [CRC_W-1:0] v);
        logic [CRC_W-1:0] r;
        for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
        return r;
    endfunction

    // Advance a CRC by one byte, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] crc,
                                                  input logic [BYTE_W-1:0] d);
        logic [CRC_W-1:0] c;
        logic [CRC_W-1:0] rp;
        c  = crc;
        rp = reflect(POLY);
        for (int i = 0; i < BYTE_W; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ rp;
            else             c = c >> 1;
        end
        return c;
    endfunction
endpackage

// File: rtl/crc16_engine.sv
// One CRC accumulator: loads its start value on init, folds in a byte on advance.
// Assumes init takes priority over advance.
module crc16_engine
    import crc16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic [CRC_W-1:0]  init_val,
    input  logic              advance,
    input  logic [BYTE_W-1:0] din,
    output logic [CRC_W-1:0]  state
);
    // Accumulator register update.
    always_ff @(posedge clk) begin
        if (!rst_n)       state <= '0;
        else if (init)    state <= init_val;
        else if (advance) state <= crc_step(state, din);
    end

    p_init_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> state == $past(init_val));
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !init && !advance |=> $stable(state));
endmodule

// File: rtl/crc16_rx_capture.sv
// Collects the two received CRC bytes, low byte first. It flags the word
// in the cycle the second byte arrives and ignores any bytes after that
// until clear. Assumes clear takes priority over take.
module crc16_rx_capture
    import crc16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take,
    input  logic [BYTE_W-1:0] din,
    output logic              word_valid,
    output logic [CRC_W-1:0]  word
);
    logic              have_lo;
    logic              full;
    logic [BYTE_W-1:0] lo_q;

    // Byte counter and low-byte holding register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            have_lo <= 1'b0;
            full    <= 1'b0;
            lo_q    <= '0;
        end else if (take && !full) begin
            if (!have_lo) begin
                lo_q    <= din;
                have_lo <= 1'b1;
            end else begin
                full <= 1'b1;
            end
        end
    end

    // Word formed from the held low byte and the incoming high byte.
    always_comb begin
        word_valid = take && have_lo && !full && !clear;
        word       = {din, lo_q};
    end

    p_full_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        full && !clear |=> full);
    p_single_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);
endmodule

// File: rtl/crc16_dual_seed.sv
// Top level. It runs a programmed-seed engine and a zero-seed engine over
// each packet and shows the selected one as the transmit CRC. After the
// packet it compares the received CRC against both. Assumes that din_valid
// and crc_valid are exclusive and that pkt_start is a one-cycle strobe.
module crc16_dual_seed
    import crc16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crc_en,
    input  logic [CRC_W-1:0]  seed,
    input  logic              tx_zero_seed,
    input  logic              pkt_start,
    input  logic              pkt_end,
    input  logic [BYTE_W-1:0] din,
    input  logic              din_valid,
    input  logic              crc_valid,
    output logic [CRC_W-1:0]  crc_out,
    output logic              chk_done,
    output logic              match_ok,
    output logic              hit_seed,
    output logic              hit_zero
);
    localparam int N_ENG = 2;

    phase_t           phase;
    logic             sel_zero_q;
    logic             done_q, hs_q, hz_q;
    logic             advance;
    logic             take;
    logic             word_valid;
    logic [CRC_W-1:0] rx_word;
    logic [CRC_W-1:0] eng_state [N_ENG];

    assign advance = din_valid && (phase == PH_DATA) && !pkt_start;
    assign take    = crc_valid && (phase == PH_TAIL) && !pkt_start;

    // Engine 0 starts from the programmed seed and engine 1 from zero.
    for (genvar g = 0; g < N_ENG; g++) begin : g_eng
        crc16_engine u_eng (
            .clk      (clk),
            .rst_n    (rst_n),
            .init     (pkt_start),
            .init_val ((g == 0) ? seed : '0),
            .advance  (advance),
            .din      (din),
            .state    (eng_state[g])
        );
    end

    crc16_rx_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (pkt_start),
        .take       (take),
        .din        (din),
        .word_valid (word_valid),
        .word       (rx_word)
    );

    // Packet phase sequencing and transmit seed selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            sel_zero_q <= 1'b0;
        end else if (pkt_start) begin
            phase      <= PH_DATA;
            sel_zero_q <= tx_zero_seed;
        end else if (phase == PH_DATA && pkt_end) begin
            phase <= PH_TAIL;
        end
    end

    // Check result registers, cleared at each start.
    always_ff @(posedge clk) begin
        if (!rst_n || pkt_start) begin
            done_q <= 1'b0;
            hs_q   <= 1'b0;
            hz_q   <= 1'b0;
        end else if (word_valid) begin
            done_q <= 1'b1;
            hs_q   <= (rx_word == eng_state[0]);
            hz_q   <= (rx_word == eng_state[1]);
        end
    end

    // Output selection and the enable override.
    always_comb begin
        crc_out  = crc_en ? (sel_zero_q ? eng_state[1] : eng_state[0]) : '0;
        chk_done = done_q;
        hit_seed = done_q && crc_en && hs_q;
        hit_zero = done_q && crc_en && hz_q;
        match_ok = done_q && (!crc_en || hs_q || hz_q);
    end

    p_start_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_start |=> !chk_done);
    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done && !pkt_start |=> chk_done);
    p_no_tail_bytes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_TAIL && !pkt_start |=> $stable(crc_out) || $changed(crc_en));
    p_disabled_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done && !crc_en |-> match_ok && !hit_seed && !hit_zero);
    p_ok_needs_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        match_ok && crc_en |-> hit_seed || hit_zero);
endmodule

// File: tb/crc16_dual_seed_test.sv
module crc16_dual_seed_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        crc_en = 1'b1;
    logic [15:0] seed = 16'h0;
    logic        tx_zero_seed = 1'b0;
    logic        pkt_start = 1'b0, pkt_end = 1'b0;
    logic [7:0]  din = 8'h0;
    logic        din_valid = 1'b0, crc_valid = 1'b0;
    logic [15:0] crc_out;
    logic        chk_done, match_ok, hit_seed, hit_zero;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    crc16_dual_seed uut (
        .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .seed(seed),
        .tx_zero_seed(tx_zero_seed), .pkt_start(pkt_start), .pkt_end(pkt_end),
        .din(din), .din_valid(din_valid), .crc_valid(crc_valid),
        .crc_out(crc_out), .chk_done(chk_done), .match_ok(match_ok),
        .hit_seed(hit_seed), .hit_zero(hit_zero)
    );

    // Behavioural CRC reference: reflected 0x8005, LSB first.
    function automatic int ref_crc(int c, int d);
        for (int i = 0; i < 8; i++) begin
            if (((c ^ (d >> i)) & 1) != 0) c = (c >> 1) ^ 32'hA001;
            else c = c >> 1;
        end
        return c & 32'hFFFF;
    endfunction

    // Reference model state.
    int m_a, m_b, m_ph, m_cnt, m_lo;
    bit m_sel, m_done, m_hs, m_hz;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_a <= 0; m_b <= 0; m_sel <= 0; m_ph <= 0; m_cnt <= 0; m_lo <= 0;
            m_done <= 0; m_hs <= 0; m_hz <= 0;
        end else if (pkt_start) begin
            m_a <= int'(seed); m_b <= 0; m_sel <= tx_zero_seed; m_ph <= 1;
            m_cnt <= 0; m_done <= 0; m_hs <= 0; m_hz <= 0;
        end else begin
            if (m_ph == 1 && din_valid) begin
                m_a <= ref_crc(m_a, int'(din));
                m_b <= ref_crc(m_b, int'(din));
            end
            if (m_ph == 1 && pkt_end) m_ph <= 2;
            if (m_ph == 2 && crc_valid && m_cnt < 2) begin
                if (m_cnt == 0) m_lo <= int'(din);
                else begin
                    m_done <= 1;
                    m_hs <= ((int'(din) << 8 | m_lo) == m_a);
                    m_hz <= ((int'(din) << 8 | m_lo) == m_b);
                end
                m_cnt <= m_cnt + 1;
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare against the model every cycle, just after the edge.
    always @(posedge clk) begin
        #1;
        cyc++;
        if (rst_n) begin
            chk("R2 crc_out", int'(crc_out), crc_en ? (m_sel ? m_b : m_a) : 0);
            chk("R6 chk_done", int'(chk_done), int'(m_done));
            chk("R7 hit_seed", int'(hit_seed), int'(m_done && crc_en && m_hs));
            chk("R7 hit_zero", int'(hit_zero), int'(m_done && crc_en && m_hz));
            chk("R7 match_ok", int'(match_ok), int'(m_done && (!crc_en || m_hs || m_hz)));
        end
    end

    task automatic idle();
        @(negedge clk);
        pkt_start = 0; pkt_end = 0; din_valid = 0; crc_valid = 0;
    endtask
    task automatic start(logic [15:0] s, logic z);
        @(negedge clk);
        pkt_start = 1; seed = s; tx_zero_seed = z; pkt_end = 0; din_valid = 0; crc_valid = 0;
        idle();
    endtask
    task automatic data(logic [7:0] b, logic last);
        @(negedge clk);
        din = b; din_valid = 1; pkt_end = last;
        idle();
    endtask
    task automatic crcb(logic [7:0] b);
        @(negedge clk);
        din = b; crc_valid = 1;
        idle();
    endtask
    task automatic send_digits(bit flip);
        for (int i = 0; i < 9; i++) data(8'(8'h31 + i) ^ ((flip && i == 4) ? 8'h04 : 8'h00), i == 8);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset crc", int'(crc_out), 0);
        chk("R1 reset done", int'({chk_done, match_ok, hit_seed, hit_zero}), 0);

        // Known vector from the programmed seed.
        start(16'hFFFF, 0);
        send_digits(0);
        chk("R2 seed FFFF", int'(crc_out), 16'h4B37);
        data(8'hAA, 0);
        chk("R5 byte after end ignored", int'(crc_out), 16'h4B37);
        crcb(8'h37);
        chk("R6 not done after one byte", int'(chk_done), 0);
        crcb(8'h4B);
        chk("R6 done", int'(chk_done), 1);
        chk("R7 seed hit", int'({match_ok, hit_seed, hit_zero}), 3'b110);
        crcb(8'h00);
        chk("R6 extra byte ignored", int'({chk_done, match_ok}), 2'b11);

        // Zero seed selected for transmit; the received CRC matches the zero engine.
        start(16'hFFFF, 1);
        chk("R4 start clears done", int'(chk_done), 0);
        send_digits(0);
        chk("R3 zero seed tx", int'(crc_out), 16'hBB3D);
        crcb(8'h3D); crcb(8'hBD);
        chk("R7 mismatch", int'(match_ok), 0);
        start(16'hFFFF, 1);
        send_digits(0);
        crcb(8'h3D); crcb(8'hBB);
        chk("R7 zero hit", int'({match_ok, hit_seed, hit_zero}), 3'b101);

        // Single bit flip in the payload must be rejected.
        start(16'hFFFF, 0);
        send_digits(1);
        crcb(8'h37); crcb(8'h4B);
        chk("R9 flipped bit rejected", int'({chk_done, match_ok}), 2'b10);

        // A byte on the start cycle is dropped.
        @(negedge clk);
        pkt_start = 1; seed = 16'h0000; tx_zero_seed = 0; din = 8'h55; din_valid = 1;
        idle();
        chk("R4 start byte ignored", int'(crc_out), 0);
        send_digits(0);
        crcb(8'h3D); crcb(8'hBB);
        chk("R7 both hit", int'({match_ok, hit_seed, hit_zero}), 3'b111);

        // CRC checking disabled.
        crc_en = 0;
        start(16'h1234, 0);
        send_digits(0);
        chk("R8 disabled crc", int'(crc_out), 0);
        crcb(8'h00); crcb(8'h00);
        chk("R8 disabled pass", int'({match_ok, hit_seed, hit_zero}), 3'b100);
        crc_en = 1;

        // Random packets of varying length, with good or corrupted trailers.
        for (int p = 0; p < 40; p++) begin
            automatic logic [15:0] s = 16'($urandom);
            automatic logic z = 1'($urandom);
            automatic int len = $urandom_range(0, 20);
            automatic int ra = int'(s), rb = 0, rc;
            start(s, z);
            for (int i = 0; i <= len; i++) begin
                automatic logic [7:0] b = (i == 0) ? 8'(len) : 8'($urandom);
                ra = ref_crc(ra, int'(b)); rb = ref_crc(rb, int'(b));
                data(b, i == len);
            end
            rc = z ? rb : ra;
            if (p % 4 == 3) rc = rc ^ 16'h0100;
            crcb(8'(rc)); crcb(8'(rc >> 8));
            chk("R7 random accept", int'(match_ok), int'(rc == ra || rc == rb));
        end

        repeat (3) idle();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule